// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block watches four external interrupt pins for a small microcontroller and turns the chosen pin condition on each one into an interrupt request. Each channel has four settings: an enable, a rising-edge select, a falling-edge select and a level polarity. With both edge selects clear, the channel works in level mode. In that mode its request follows the pin, active high or active low. With one edge select set, the channel catches that single transition. With both set, it catches either transition.

Each pin first passes through a two-flop synchroniser. A history flop then holds the synchronised value from one clock earlier. The history flop keeps running while a channel is disabled or in level mode, so changing the mode or the enable never makes a false edge. A caught edge sets a per-channel pending flag. The flag stays set until software writes a 1 to its bit in the pending register. Software sets the configuration through a byte-wide register port with a combinational read path.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, all configuration registers read 00h, all pending flags are 0 and every `irq_req` bit is 0.
- R2: The register map is as follows. Pending is at ABh, rising-edge select at ACh, falling-edge select at ADh, polarity at AEh and enable at AFh. Bit n of each register belongs to channel n. Only bits 3:0 are stored, bits 7:4 read as 0, and any other address reads 00h.
- R3: While a channel's enable bit is 0, its `irq_req` bit is 0 and its pending flag is never set.
- R4: In level mode with polarity 0, an enabled channel's `irq_req` equals the pin value seen two clock edges earlier.
- R5: In level mode with polarity 1, an enabled channel's `irq_req` equals the inverse of the pin value seen two clock edges earlier.
- R6: With only the rising select set, a low-to-high pin transition sets the pending flag on the third clock edge after the change, and `irq_req` then stays 1.
- R7: With only the falling select set, a high-to-low transition sets the pending flag with the same timing as R6.
- R8: With both selects set, either transition sets the pending flag.
- R9: Writing pending with bit n = 1 clears flag n, and a 0 bit leaves its flag unchanged. An edge caught on the same clock as the clear leaves the flag set.
- R10: Changing the enable or the edge selects while the pin is held steady never sets a pending flag.
- R11: In either edge mode the polarity bit has no effect on `irq_req`.
- R12: In level mode no pending flag is set, and `irq_req` drops as soon as the pin leaves the active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous external interrupt pins, one per channel |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_req | output | 4 | Per-channel interrupt request |

## Verification
A pin change reaches the synchronised value on the second rising edge after the change. A level-mode request therefore shows after that edge. An edge-mode request shows only after the third edge, once the pending flag has been registered. A register write takes effect on the edge that samples the strobe. Read data is combinational and is valid in the same cycle as the address. The bench steps a behavioural model on the same edge as the design, using a queue of past pin samples. It compares `irq_req` and `reg_rdata` at every falling edge, half a cycle after all of these updates have settled, so each latency is checked exactly and not just eventually.

// File: rtl/eid_pkg.sv
package eid_pkg;

    localparam logic [7:0] ADDR_PEND = 8'hAB;
    localparam logic [7:0] ADDR_RISE = 8'hAC;
    localparam logic [7:0] ADDR_FALL = 8'hAD;
    localparam logic [7:0] ADDR_POL  = 8'hAE;
    localparam logic [7:0] ADDR_EN   = 8'hAF;

    // trigger mode is {rise_sel, fall_sel}
    typedef enum logic [1:0] {
        MODE_LEVEL = 2'b00,
        MODE_FALL  = 2'b01,
        MODE_RISE  = 2'b10,
        MODE_BOTH  = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.hist = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.hist;

endmodule

// File: rtl/eid_chan.sv
module eid_chan
    import eid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic prev,
    input  logic en,
    input  logic rise_sel,
    input  logic fall_sel,
    input  logic pol,
    input  logic clr,
    output logic pend,
    output logic irq
);

    typedef struct packed {
        logic pend;
    } chan_t;

    chan_t      st_d, st_q;
    trig_mode_e mode;
    logic       hit;

    assign mode = trig_mode_e'({rise_sel, fall_sel});

    always_comb begin
        unique case (mode)
            MODE_RISE: hit = cur & ~prev;
            MODE_FALL: hit = ~cur & prev;
            MODE_BOTH: hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase

        st_d = st_q;
        if (clr)       st_d.pend = 1'b0;
        if (en && hit) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign irq  = en & ((mode == MODE_LEVEL) ? (cur ^ pol) : st_q.pend);

endmodule

// File: rtl/eid_regs.sv
module eid_regs
    import eid_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] pend_in,
    output logic [NCH-1:0] en,
    output logic [NCH-1:0] rise_sel,
    output logic [NCH-1:0] fall_sel,
    output logic [NCH-1:0] pol,
    output logic [NCH-1:0] clr,
    output logic [DW-1:0]  rdata
);

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] rise;
        logic [NCH-1:0] fall;
        logic [NCH-1:0] pol;
    } cfg_t;

    cfg_t st_d, st_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DW-1:NCH];

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (we) begin
            if (addr == AW'(ADDR_EN))   st_d.en   = wdata[NCH-1:0];
            if (addr == AW'(ADDR_RISE)) st_d.rise = wdata[NCH-1:0];
            if (addr == AW'(ADDR_FALL)) st_d.fall = wdata[NCH-1:0];
            if (addr == AW'(ADDR_POL))  st_d.pol  = wdata[NCH-1:0];
            if (addr == AW'(ADDR_PEND)) clr       = wdata[NCH-1:0];
        end

        rdata = '0;
        if (addr == AW'(ADDR_EN))   rdata[NCH-1:0] = st_q.en;
        if (addr == AW'(ADDR_RISE)) rdata[NCH-1:0] = st_q.rise;
        if (addr == AW'(ADDR_FALL)) rdata[NCH-1:0] = st_q.fall;
        if (addr == AW'(ADDR_POL))  rdata[NCH-1:0] = st_q.pol;
        if (addr == AW'(ADDR_PEND)) rdata[NCH-1:0] = pend_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en       = st_q.en;
    assign rise_sel = st_q.rise;
    assign fall_sel = st_q.fall;
    assign pol      = st_q.pol;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_in,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] irq_req
);

    logic [NCH-1:0] pin_cur, pin_prev;
    logic [NCH-1:0] cfg_en, cfg_rise, cfg_fall, cfg_pol, clr_vec;
    logic [NCH-1:0] pend_vec;

    eid_sync #(.W(NCH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    eid_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pend_in (pend_vec),
        .en      (cfg_en),
        .rise_sel(cfg_rise),
        .fall_sel(cfg_fall),
        .pol     (cfg_pol),
        .clr     (clr_vec),
        .rdata   (reg_rdata)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        eid_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur     (pin_cur[ch]),
            .prev    (pin_prev[ch]),
            .en      (cfg_en[ch]),
            .rise_sel(cfg_rise[ch]),
            .fall_sel(cfg_fall[ch]),
            .pol     (cfg_pol[ch]),
            .clr     (clr_vec[ch]),
            .pend    (pend_vec[ch]),
            .irq     (irq_req[ch])
        );
    end

endmodule

// File: rtl/eid_checker.sv
module eid_checker #(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic [NCH-1:0]    clr_bits,
    input logic [DW-NCH-1:0] rdata_hi,
    input logic [NCH-1:0]    irq,
    input logic [NCH-1:0]    en,
    input logic [NCH-1:0]    rise,
    input logic [NCH-1:0]    fall,
    input logic [NCH-1:0]    pend
);

    logic pend_wr;
    assign pend_wr = reg_we && (reg_addr == AW'(eid_pkg::ADDR_PEND));

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_hi == '0); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~en) == '0); // R3

    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((pend & ~$past(pend) & ~$past(en)) == '0)); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr |=> (($past(pend) & ~pend) == '0)); // R9

    AST_CLEAR_ONLY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> (($past(pend) & ~pend & ~$past(clr_bits)) == '0)); // R9

    AST_LEVEL_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((pend & ~$past(pend) & ~$past(rise | fall)) == '0)); // R12

endmodule

bind ext_irq_detect eid_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .clr_bits(reg_wdata[3:0]),
    .rdata_hi(reg_rdata[7:4]),
    .irq     (irq_req),
    .en      (cfg_en),
    .rise    (cfg_rise),
    .fall    (cfg_fall),
    .pend    (pend_vec)
);

// File: tb/ext_irq_detect_test.sv
`timescale 1ns/1ps
module ext_irq_detect_test;

    localparam logic [7:0] A_PEND = 8'hAB;
    localparam logic [7:0] A_RISE = 8'hAC;
    localparam logic [7:0] A_FALL = 8'hAD;
    localparam logic [7:0] A_POL  = 8'hAE;
    localparam logic [7:0] A_EN   = 8'hAF;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] pin = 0;
    logic       we = 0;
    logic [7:0] addr = A_PEND;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [3:0] irq;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    ext_irq_detect uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin),
        .reg_we   (we),
        .reg_addr (addr),
        .reg_wdata(wdata),
        .reg_rdata(rdata),
        .irq_req  (irq)
    );

    // behavioural reference model
    logic [3:0] m_en = 0, m_rise = 0, m_fall = 0, m_pol = 0, m_pend = 0;
    logic [3:0] hist[$] = '{4'h0, 4'h0, 4'h0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_rise = 0; m_fall = 0; m_pol = 0; m_pend = 0;
            hist = '{4'h0, 4'h0, 4'h0};
        end else begin
            for (int ch = 0; ch < 4; ch++) begin
                bit up, dn, hit;
                up  = hist[1][ch] && !hist[2][ch];
                dn  = !hist[1][ch] && hist[2][ch];
                hit = (m_rise[ch] && up) || (m_fall[ch] && dn);
                if (we && addr == A_PEND && wdata[ch]) m_pend[ch] = 1'b0;
                if (m_en[ch] && hit) m_pend[ch] = 1'b1;
            end
            if (we) begin
                if (addr == A_EN)   m_en   = wdata[3:0];
                if (addr == A_RISE) m_rise = wdata[3:0];
                if (addr == A_FALL) m_fall = wdata[3:0];
                if (addr == A_POL)  m_pol  = wdata[3:0];
            end
            hist.push_front(pin);
            void'(hist.pop_back());
        end
    end

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int ch = 0; ch < 4; ch++) begin
            if (!m_en[ch])                     r[ch] = 1'b0;
            else if (m_rise[ch] || m_fall[ch]) r[ch] = m_pend[ch];
            else                               r[ch] = hist[1][ch] ^ m_pol[ch];
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_rd();
        case (addr)
            A_PEND:  return {4'h0, m_pend};
            A_RISE:  return {4'h0, m_rise};
            A_FALL:  return {4'h0, m_fall};
            A_POL:   return {4'h0, m_pol};
            A_EN:    return {4'h0, m_en};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("irq_req", {4'h0, irq}, {4'h0, exp_irq()});
            check("reg_rdata", rdata, exp_rd());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        we = 1; addr = a; wdata = d;
        tick(1);
        we = 0; addr = A_PEND; wdata = 0;
    endtask

    task automatic rd(logic [7:0] a);
        addr = a;
        tick(1);
        addr = A_PEND;
    endtask

    task automatic pins(logic [3:0] v, int n);
        pin = v;
        tick(n);
    endtask

    initial begin
        tick(3);
        cur_req = "R1";
        rd(A_PEND); rd(A_RISE); rd(A_FALL); rd(A_POL); rd(A_EN);
        rst_n = 1;
        tick(2);
        rd(A_EN); rd(A_POL);

        cur_req = "R2";
        wr(A_RISE, 8'hFF); wr(A_FALL, 8'hA5); wr(A_POL, 8'h3C); wr(A_EN, 8'hF0);
        rd(A_RISE); rd(A_FALL); rd(A_POL); rd(A_EN); rd(8'h10); rd(8'hAA);
        wr(A_RISE, 0); wr(A_FALL, 0); wr(A_POL, 0); wr(A_EN, 0);

        cur_req = "R3";
        wr(A_RISE, 8'h0F);
        pins(4'hF, 5); pins(4'h0, 5); rd(A_PEND);
        wr(A_RISE, 0);
        pins(4'hF, 5); pins(4'h0, 5);

        cur_req = "R4";
        wr(A_EN, 8'h0F);
        pins(4'h5, 4); pins(4'hA, 4); pins(4'hF, 1); pins(4'h0, 4);

        cur_req = "R5";
        wr(A_POL, 8'h0F);
        pins(4'h3, 4); pins(4'hC, 4); pins(4'hF, 4);

        cur_req = "R12";
        wr(A_POL, 8'h05);
        pins(4'h0, 2); pins(4'h9, 3); pins(4'h6, 1); rd(A_PEND); pins(4'h0, 4);

        cur_req = "R6";
        wr(A_POL, 0); wr(A_RISE, 8'h0F);
        pins(4'h3, 5); rd(A_PEND); pins(4'h0, 5); rd(A_PEND);

        cur_req = "R9";
        wr(A_PEND, 8'h01); rd(A_PEND);
        wr(A_PEND, 8'h00); rd(A_PEND);
        wr(A_PEND, 8'hFF); rd(A_PEND);
        pin = 4'h1; tick(2);
        wr(A_PEND, 8'h01); rd(A_PEND);
        wr(A_PEND, 8'h01); pins(4'h0, 4);

        cur_req = "R11";
        wr(A_POL, 8'h0F);
        pins(4'hC, 5); pins(4'h0, 4); wr(A_PEND, 8'h0F); tick(3);

        cur_req = "R7";
        wr(A_POL, 0); wr(A_RISE, 0); wr(A_FALL, 8'h0F);
        pins(4'hF, 5); rd(A_PEND); pins(4'h6, 5); rd(A_PEND);
        wr(A_PEND, 8'h0F); pins(4'h0, 5);
        wr(A_PEND, 8'h0F); tick(2);

        cur_req = "R8";
        wr(A_RISE, 8'h0F);
        pins(4'h5, 5); rd(A_PEND); wr(A_PEND, 8'h0F);
        pins(4'h0, 5); rd(A_PEND); wr(A_PEND, 8'h0F);
        pins(4'h1, 1); pins(4'h0, 1); pins(4'h1, 5);

        cur_req = "R10";
        wr(A_PEND, 8'h0F);
        pins(4'hF, 4); wr(A_PEND, 8'h0F);
        wr(A_EN, 0); wr(A_RISE, 0); wr(A_FALL, 0); tick(2);
        wr(A_EN, 8'h0F); tick(2);
        wr(A_RISE, 8'h0F); tick(3);
        wr(A_FALL, 8'h0F); tick(3);
        wr(A_RISE, 0); tick(3); rd(A_PEND);
        wr(A_EN, 0); pins(4'h0, 4); wr(A_EN, 8'h0F); tick(4); rd(A_PEND);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule